// File: doc/BRIEF.md
# Register-Access Mailbox Command Engine

This block sits on the responding side of a command mailbox. When a command is posted, it decodes the 32-bit command word. It then runs register-access commands against a byte-wide register file that it holds internally. The payload comes from a 16-byte write buffer, which the block reads in parallel and which must stay steady until the command completes.

Three operations are supported:
- a write of one to five registers;
- a read of one to five registers, with the fetched bytes placed into a 16-byte read buffer through a byte write port;
- a single masked read-modify-write.

Register addresses travel as packed 16-bit little-endian pairs. The engine handles one item per clock and then signals completion on `done`, with `err` qualifying the outcome. A malformed command is refused as a whole, before any register is touched. A side port gives direct read access to the register file at any time and write access while the engine is idle. A surrounding subsystem uses this port to initialise the registers and to observe them.

Top module: `regmb_cmd_engine`

## Requirements
- R1: While reset is held and after it is released, `done`, `err`, `rbuf_we` stay low until a command is accepted.
- R2: Command word fields: bits [7:0] are the message type and must be 0xFF; bits [15:12] are the operation (0 write, 1 read, 2 read-modify-write, any other value invalid); bits [23:16] are the payload size in bytes. Bits [11:8] and [31:24] have no effect.
- R3: Write of n items: item i takes its address from write-buffer bytes 2i (low) and 2i+1 (high) and its data from byte 2n+i. The size must equal 3n. Items are applied in ascending order, so when an address repeats, the later item's data remains.
- R4: Read of n items: the size must equal 2n and the addresses are laid out as in R3. Item i's register value is written to read-buffer offset i, for i = 0 to n-1, and to no other offset.
- R5: Read-modify-write: the size must equal 4. Bytes 0 and 1 hold the address, byte 2 the new value and byte 3 the mask. The register becomes (old AND NOT mask) OR (value AND mask).
- R6: The item count n must lie between 1 and MAX_ITEMS (5).
- R7: A command that breaks R2, R3, R4, R5 or R6 completes with `done` and `err` high at the accepting clock edge. It changes no register and writes no read-buffer byte.
- R8: A valid command with n items performs one item per cycle. `done` rises at the n-th clock edge after the accepting edge, stays high for exactly one cycle, and every read-buffer byte has been written by then.
- R9: While a command is in progress, `cmd_valid` is ignored, and so are writes on the side port.
- R10: Only the low RF_AW bits of a 16-bit register address select an entry. Addresses that differ only in higher bits reach the same register. The side port reads the register file combinationally.
- R11: `err` is low when a valid command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command posted strobe |
| cmd_word | input | 32 | Command word |
| wbuf_bytes | input | 128 | Write-buffer contents, byte k at bits [8k+7:8k] |
| rbuf_we | output | 1 | Read-buffer byte write strobe |
| rbuf_idx | output | 4 | Read-buffer byte offset |
| rbuf_wdata | output | 8 | Read-buffer byte data |
| rf_addr | input | 6 | Side-port register index |
| rf_we | input | 1 | Side-port write enable (idle only) |
| rf_wdata | input | 8 | Side-port write data |
| rf_rdata | output | 8 | Side-port read data |
| done | output | 1 | Command complete, one-cycle pulse |
| err | output | 1 | Command rejected, valid with done |

## Verification
The bench builds the engine with its default parameters: a 64-entry register file (RF_AW = 6), 16-byte buffers and a limit of five items. With only six address bits decoded, random 16-bit addresses collide often. This means repeated addresses inside one vector write, and aliasing through the ignored upper bits, both occur in random traffic as well as in directed cases. Because the limit is five, the full-size write uses 15 of the 16 payload bytes, and both a count of six and a count of zero are within reach to test rejection.

// File: rtl/regmb_pkg.sv
package regmb_pkg;
  localparam logic [7:0] MSG_REGACC = 8'hFF;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_RMW = 2'd2
  } op_e;
endpackage

// File: rtl/regmb_decode.sv
module regmb_decode
  import regmb_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int CW        = 3
) (
  input  logic [31:0]   cmd_word,
  output logic          ok,
  output op_e           op,
  output logic [CW-1:0] cnt
);
  logic [7:0] typ, size, n;
  logic [3:0] sub;
  logic       shape_ok;

  assign typ  = cmd_word[7:0];
  assign sub  = cmd_word[15:12];
  assign size = cmd_word[23:16];

  always_comb begin
    op       = OP_WR;
    n        = '0;
    shape_ok = 1'b0;
    case (sub)
      4'd0: begin
        op       = OP_WR;
        shape_ok = ((size % 8'd3) == 8'd0);
        n        = size / 8'd3;
      end
      4'd1: begin
        op       = OP_RD;
        shape_ok = !size[0];
        n        = {1'b0, size[7:1]};
      end
      4'd2: begin
        op       = OP_RMW;
        shape_ok = (size == 8'd4);
        n        = 8'd1;
      end
      default: begin
        shape_ok = 1'b0;
      end
    endcase
  end

  assign ok  = (typ == MSG_REGACC) && shape_ok && (n != 8'd0) && (n <= 8'(MAX_ITEMS));
  assign cnt = n[CW-1:0];
endmodule

// File: rtl/regmb_payload.sv
module regmb_payload
  import regmb_pkg::*;
#(
  parameter int WB_BYTES = 16,
  parameter int CW       = 3
) (
  input  logic [8*WB_BYTES-1:0] wbuf,
  input  op_e                   op,
  input  logic [CW-1:0]         cnt,
  input  logic [CW-1:0]         idx,
  output logic [15:0]           item_addr,
  output logic [7:0]            item_val,
  output logic [7:0]            item_mask
);
  function automatic logic [7:0] getb(input logic [8*WB_BYTES-1:0] v, input int i);
    if (i < WB_BYTES) return v[8*i +: 8];
    return 8'h00;
  endfunction

  int lo_i, dat_i;

  always_comb begin
    lo_i      = 2 * int'(idx);
    dat_i     = 2 * int'(cnt) + int'(idx);
    item_addr = {getb(wbuf, lo_i + 1), getb(wbuf, lo_i)};
    item_val  = (op == OP_RMW) ? getb(wbuf, 2) : getb(wbuf, dat_i);
    item_mask = getb(wbuf, 3);
  end
endmodule

// File: rtl/regmb_regfile.sv
module regmb_regfile #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];

  always_ff @(posedge clk) begin
    if (a_we)      mem[a_addr] <= a_wdata;
    else if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/regmb_cmd_engine.sv
module regmb_cmd_engine
  import regmb_pkg::*;
#(
  parameter int RF_AW     = 6,
  parameter int WB_BYTES  = 16,
  parameter int RB_BYTES  = 16,
  parameter int MAX_ITEMS = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [31:0]                 cmd_word,
  input  logic [8*WB_BYTES-1:0]       wbuf_bytes,
  output logic                        rbuf_we,
  output logic [$clog2(RB_BYTES)-1:0] rbuf_idx,
  output logic [7:0]                  rbuf_wdata,
  input  logic [RF_AW-1:0]            rf_addr,
  input  logic                        rf_we,
  input  logic [7:0]                  rf_wdata,
  output logic [7:0]                  rf_rdata,
  output logic                        done,
  output logic                        err
);
  localparam int CW  = $clog2(MAX_ITEMS + 1);
  localparam int RBW = $clog2(RB_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // decode of the posted command
  logic          dec_ok;
  op_e           dec_op;
  logic [CW-1:0] dec_cnt;

  regmb_decode #(.MAX_ITEMS(MAX_ITEMS), .CW(CW)) u_dec (
    .cmd_word (cmd_word),
    .ok       (dec_ok),
    .op       (dec_op),
    .cnt      (dec_cnt)
  );

  // control state
  logic          busy_q, busy_d;
  op_e           op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d, idx_q, idx_d;
  logic          done_q, done_d, err_q, err_d;
  logic          load_en;

  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    load_en = 1'b0;
    if (!busy_q) begin
      if (cmd_valid) begin
        if (dec_ok) begin
          load_en = 1'b1;
          busy_d  = 1'b1;
          op_d    = dec_op;
          cnt_d   = dec_cnt;
          idx_d   = '0;
        end else begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end
      end
    end else begin
      idx_d = idx_q + 1'b1;
      if (idx_q == cnt_q - 1'b1) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q  <= OP_WR;
      cnt_q <= '0;
    end else if (load_en) begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
    end
  end

  // item selection from the payload
  logic [15:0] item_addr;
  logic [7:0]  item_val, item_mask;

  regmb_payload #(.WB_BYTES(WB_BYTES), .CW(CW)) u_pay (
    .wbuf      (wbuf_bytes),
    .op        (op_q),
    .cnt       (cnt_q),
    .idx       (idx_q),
    .item_addr (item_addr),
    .item_val  (item_val),
    .item_mask (item_mask)
  );

  // register file access
  logic       eng_we;
  logic [7:0] eng_wdata, eng_rdata;

  assign eng_we    = busy_q && (op_q != OP_RD);
  assign eng_wdata = (op_q == OP_RMW) ? ((eng_rdata & ~item_mask) | (item_val & item_mask))
                                      : item_val;

  regmb_regfile #(.AW(RF_AW)) u_rf (
    .clk     (clk),
    .a_we    (eng_we),
    .a_addr  (item_addr[RF_AW-1:0]),
    .a_wdata (eng_wdata),
    .a_rdata (eng_rdata),
    .b_we    (rf_we && !busy_q),
    .b_addr  (rf_addr),
    .b_wdata (rf_wdata),
    .b_rdata (rf_rdata)
  );

  assign rbuf_we    = busy_q && (op_q == OP_RD);
  assign rbuf_idx   = {{(RBW-CW){1'b0}}, idx_q};
  assign rbuf_wdata = eng_rdata;
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/regmb_cmd_engine_chk.sv
module regmb_cmd_engine_chk #(
  parameter int MAX_ITEMS = 5,
  parameter int RBW       = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           busy,
  input logic           dec_ok,
  input logic           eng_we,
  input logic           rbuf_we,
  input logic [RBW-1:0] rbuf_idx,
  input logic           done,
  input logic           err
);
  logic accept;
  assign accept = cmd_valid && !busy;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |=> !done); // R8
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7
  AST_BAD_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_ok) |=> (done && err)); // R7
  AST_BAD_CMD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_ok) |=> (!eng_we && !rbuf_we)); // R7
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eng_we && !rbuf_we)); // R1
  AST_RBUF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_we |-> (rbuf_idx < RBW'(MAX_ITEMS))); // R4
  AST_GOOD_CMD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_ok) |=> (busy && !err)); // R11
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_we && rbuf_we)); // R4
  AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !err); // R9
endmodule

bind regmb_cmd_engine regmb_cmd_engine_chk #(
  .MAX_ITEMS (MAX_ITEMS),
  .RBW       (RBW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .busy      (busy_q),
  .dec_ok    (dec_ok),
  .eng_we    (eng_we),
  .rbuf_we   (rbuf_we),
  .rbuf_idx  (rbuf_idx),
  .done      (done),
  .err       (err)
);

// File: tb/regmb_cmd_engine_bench.sv
module regmb_cmd_engine_bench;
  localparam int AW = 6;
  localparam int NREG = 1 << AW;

  logic         clk, rst_n, cmd_valid;
  logic [31:0]  cmd_word;
  logic [127:0] wbuf;
  logic         rbuf_we;
  logic [3:0]   rbuf_idx;
  logic [7:0]   rbuf_wdata;
  logic [AW-1:0] rf_addr;
  logic         rf_we;
  logic [7:0]   rf_wdata, rf_rdata;
  logic         done, err;

  regmb_cmd_engine u_regmb_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .wbuf_bytes(wbuf), .rbuf_we(rbuf_we), .rbuf_idx(rbuf_idx), .rbuf_wdata(rbuf_wdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NREG];
  logic [7:0] rcap [16];
  int rbuf_writes = 0, done_seen = 0;

  always @(posedge clk) if (rbuf_we) begin
    rcap[rbuf_idx] <= rbuf_wdata;
    rbuf_writes    <= rbuf_writes + 1;
  end
  always @(negedge clk) if (done) done_seen <= done_seen + 1;

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [7:0] typ, input logic [3:0] sub,
                                         input logic [7:0] size);
    logic [31:0] r = $urandom;
    r[7:0] = typ; r[15:12] = sub; r[23:16] = size;
    return r;
  endfunction

  function automatic logic [7:0] rmw_f(input logic [7:0] o, input logic [7:0] v, input logic [7:0] m);
    return (o & ~m) | (v & m);
  endfunction

  task automatic setb(input int i, input logic [7:0] b);
    wbuf[8*i +: 8] = b;
  endtask

  task automatic issue(input logic [31:0] w, output int lat, output bit e);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0; lat = 1;
    while (!done && lat < 30) begin @(negedge clk); lat++; end
    e = err;
  endtask

  task automatic sweep(input string tag);
    bit bad = 0; int where = 0; logic [7:0] a = 0, x = 0;
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      rf_addr = AW'(i); #0.1;
      if (!bad && rf_rdata !== model[i]) begin bad = 1; where = i; a = rf_rdata; x = model[i]; end
    end
    if (bad) $display("FAIL-detail register %0d differs", where);
    check(!bad, tag, a, x);
  endtask

  // valid write of n items, addresses given
  task automatic do_write(input int n, input logic [15:0] ad [5], input string tag);
    int lat; bit e; logic [7:0] d;
    wbuf = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < n; i++) begin
      setb(2*i, ad[i][7:0]); setb(2*i+1, ad[i][15:8]);
    end
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom); setb(2*n+i, d); model[ad[i][AW-1:0]] = d;
    end
    issue(mk_cmd(8'hFF, 4'd0, 8'(3*n)), lat, e);
    check(lat == n+1, {tag, " R8 write latency"}, lat, n+1);
    check(!e, {tag, " R11 write err"}, e, 0);
    sweep({tag, " R3 write contents"});
  endtask

  task automatic do_read(input int n, input logic [15:0] ad [5], input string tag);
    int lat, w0; bit e; bit ok = 1;
    wbuf = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < n; i++) begin
      setb(2*i, ad[i][7:0]); setb(2*i+1, ad[i][15:8]);
    end
    for (int i = 0; i < 16; i++) rcap[i] = 8'hxx;
    w0 = rbuf_writes;
    issue(mk_cmd(8'hFF, 4'd1, 8'(2*n)), lat, e);
    check(lat == n+1, {tag, " R8 read latency"}, lat, n+1);
    check(!e, {tag, " R11 read err"}, e, 0);
    check(rbuf_writes - w0 == n, {tag, " R4 rbuf write count"}, rbuf_writes - w0, n);
    for (int i = 0; i < n; i++)
      if (rcap[i] !== model[ad[i][AW-1:0]]) begin
        ok = 0; $display("FAIL-detail offset %0d", i);
      end
    check(ok, {tag, " R4 read data"}, ok, 1);
  endtask

  task automatic do_rmw(input logic [15:0] ad, input logic [7:0] v, input logic [7:0] m,
                        input string tag);
    int lat; bit e;
    wbuf = {$urandom, $urandom, $urandom, $urandom};
    setb(0, ad[7:0]); setb(1, ad[15:8]); setb(2, v); setb(3, m);
    model[ad[AW-1:0]] = rmw_f(model[ad[AW-1:0]], v, m);
    issue(mk_cmd(8'hFF, 4'd2, 8'd4), lat, e);
    check(lat == 2 && !e, {tag, " R8 R5 rmw completion"}, lat, 2);
    sweep({tag, " R5 rmw contents"});
  endtask

  task automatic do_bad(input logic [31:0] w, input string tag);
    int lat, w0; bit e;
    wbuf = {$urandom, $urandom, $urandom, $urandom};
    w0 = rbuf_writes;
    issue(w, lat, e);
    check(lat == 1 && e, {tag, " R7 rejected at accept"}, {lat[7:0], 7'd0, e}, 16'h0101);
    check(rbuf_writes == w0, {tag, " R7 no rbuf write"}, rbuf_writes - w0, 0);
    sweep({tag, " R7 registers untouched"});
  endtask

  initial begin
    logic [15:0] ad [5];
    int lat, kind, n, w0, d0;
    bit e;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; wbuf = '0;
    rf_addr = '0; rf_we = 1'b0; rf_wdata = '0;
    repeat (3) @(negedge clk);
    check(!done && !err && !rbuf_we, "R1 outputs in reset", {done, err, rbuf_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !err && !rbuf_we, "R1 outputs after reset", {done, err, rbuf_we}, 0);

    // preload through side port
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rf_we = 1'b1; rf_addr = AW'(i); rf_wdata = 8'($urandom); model[i] = rf_wdata;
    end
    @(negedge clk); rf_we = 1'b0;
    sweep("R10 side port preload");

    // directed: full-length write with a repeated address (later wins)
    ad = '{16'h0003, 16'h0011, 16'h0003, 16'h0020, 16'h0007};
    do_write(5, ad, "R3 dup-address write");
    // aliasing through upper address bits
    ad = '{16'hA805, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
    do_write(1, ad, "R10 alias write");
    ad = '{16'h0005, 16'h7FC5, 16'h0003, 16'h0011, 16'h0020};
    do_read(5, ad, "R10 R4 alias read");
    // rmw with empty and full masks and a mixed one
    do_rmw(16'h0009, 8'hA5, 8'h00, "R5 mask none");
    do_rmw(16'h0009, 8'h3C, 8'hFF, "R5 mask all");
    do_rmw(16'hFF09, 8'hF0, 8'h5A, "R5 mask mixed");
    // rejections
    do_bad(mk_cmd(8'hFE, 4'd0, 8'd3), "R2 wrong type");
    do_bad(mk_cmd(8'hFF, 4'd3, 8'd3), "R2 unknown op");
    do_bad(mk_cmd(8'hFF, 4'd0, 8'd7), "R3 size not 3n");
    do_bad(mk_cmd(8'hFF, 4'd1, 8'd5), "R4 odd read size");
    do_bad(mk_cmd(8'hFF, 4'd2, 8'd3), "R5 rmw size");
    do_bad(mk_cmd(8'hFF, 4'd1, 8'd12), "R6 count six");
    do_bad(mk_cmd(8'hFF, 4'd0, 8'd0), "R6 count zero");

    // R9: a second command and a side write during a busy write are dropped
    wbuf = '0;
    for (int i = 0; i < 5; i++) begin setb(2*i, 8'(i)); setb(10+i, 8'($urandom)); model[i] = wbuf[8*(10+i) +: 8]; end
    w0 = rbuf_writes; d0 = done_seen;
    @(negedge clk); cmd_valid = 1'b1; cmd_word = mk_cmd(8'hFF, 4'd0, 8'd15);
    @(negedge clk); cmd_word = mk_cmd(8'hFF, 4'd1, 8'd2);
    rf_we = 1'b1; rf_addr = AW'(40); rf_wdata = ~model[40];
    @(negedge clk); cmd_valid = 1'b0; rf_we = 1'b0;
    repeat (12) @(negedge clk);
    check(done_seen - d0 == 1, "R9 single completion", done_seen - d0, 1);
    check(rbuf_writes == w0, "R9 intruding read dropped", rbuf_writes - w0, 0);
    sweep("R9 side write dropped while busy");

    // random traffic
    for (int t = 0; t < 70; t++) begin
      kind = $urandom % 4;
      n = 1 + ($urandom % 5);
      for (int i = 0; i < 5; i++) ad[i] = 16'($urandom);
      if ($urandom % 3 == 0) ad[n-1] = ad[0];
      case (kind)
        0: do_write(n, ad, "R3 random write");
        1: do_read(n, ad, "R4 random read");
        2: do_rmw(ad[0], 8'($urandom), 8'($urandom), "R5 random rmw");
        default: begin
          case ($urandom % 4)
            0: do_bad(mk_cmd(8'($urandom % 255), 4'd0, 8'(3*n)), "R2 random bad type");
            1: do_bad(mk_cmd(8'hFF, 4'(3 + $urandom % 13), 8'(2*n)), "R2 random bad op");
            2: do_bad(mk_cmd(8'hFF, 4'd0, 8'(3*(6 + $urandom % 20))), "R6 random over-count");
            default: do_bad(mk_cmd(8'hFF, 4'd1, 8'(2*n + 1)), "R4 random odd size");
          endcase
        end
      endcase
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule